// File: doc/BRIEF.md
# Cascaded Codec Frame-Count DAC Loader

This block lives in one codec of a daisy chain of serial codecs that share a framed serial link carrying 16-bit words. Words arrive MSB first on `sdi`, and a pulse on `sdifs` marks the MSB. A local sample timer divides the serial clock into sample periods. Within each period the block counts completed input words. Every word that arrives before the programmed cascade length is reached is passed down the chain on `sdo` with its own `sdofs` pulse. The word that reaches the length is copied into the DAC register instead.

The cascade length comes from a 3-bit device-count input that holds the length minus one. A one-cycle `dac_load` strobe marks each DAC register update. A sticky `overrun` flag records any sample period that ended after some of its words had arrived but before the full set. After the load, further words in the same period are ignored until the next sample event.

Top module: `cfl_cascade_loader`

## Requirements
- R1: A word is 16 bits sampled MSB first, one bit per clock. `sdifs` is high in the cycle of the MSB. An `sdifs` pulse during a word in progress abandons that word and starts a new one.
- R2: The cascade length is `dev_count` + 1. The value 000b means 1 device and 111b means 8 devices, and the reset value used by the bench is 000b.
- R3: When a completed word brings the count for the current sample period to the cascade length, `dac_word` takes that word and `dac_load` is high for exactly one cycle. Both change in the cycle right after the word's last bit. `dac_word` changes at no other time.
- R4: Each word completed while the count stays below the cascade length is sent out on `sdo` MSB first. Sending starts in the cycle after its last bit, which is one word time after its MSB. `sdofs` is high only with the MSB, and `sdo` is 0 when nothing is being sent.
- R5: After the load, further words in the same sample period are neither forwarded nor loaded, and `dac_word` keeps the loaded value.
- R6: A sample event (`smp_tick` high for one cycle) occurs every 256 × 2^`period_sel` clock cycles: 256, 512, 1024 or 2048.
- R7: A sample event clears the word count. A word whose last bit falls in the same cycle as the sample event counts as the first word of the new period.
- R8: `overrun` becomes 1 when a sample event arrives after 1 to (length − 1) words of the period have been counted. A period with no words, or one that completed its load, does not set it. Once set, it stays 1 until reset.
- R9: During and right after reset, `sdo`, `sdofs`, `dac_load` and `overrun` are 0 and `dac_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| period_sel | input | 2 | Sample period select: 256 × 2^value cycles |
| dev_count | input | 3 | Cascade length minus one |
| sdi | input | 1 | Serial data in, MSB first |
| sdifs | input | 1 | Input frame sync, high with the MSB |
| sdo | output | 1 | Serial data out to the next device |
| sdofs | output | 1 | Output frame sync, high with the forwarded MSB |
| smp_tick | output | 1 | One-cycle sample event |
| dac_word | output | 16 | DAC register |
| dac_load | output | 1 | One-cycle strobe when `dac_word` is loaded |
| overrun | output | 1 | Sticky flag for a sample period that ended short |

## Verification
The assertions check, on every cycle, the invariants that are local in time:
- completed words are never adjacent;
- the word count stays bounded;
- a filled period blocks both forwarding and loading;
- a sample event clears the counter;
- `overrun` never falls;
- `dac_word` moves only under `dac_load`;
- a forward request never clobbers a word still being sent.

Only the bench scenarios can show the end-to-end results: which words are forwarded and which is loaded for each device count, the exact load cycle, the sample period length, the handling of a word that ends on the sample event, resynchronisation in mid-word, and the overrun decision across a whole period.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned DC_W      = 3;
  localparam int unsigned CNT_W     = DC_W + 1;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned BASE_LOG2 = 8;
  localparam int unsigned TMR_W     = BASE_LOG2 + (1 << SEL_W) - 1;
endpackage

// File: rtl/cfl_sample_timer.sv
module cfl_sample_timer #(
  parameter int unsigned SEL_W     = cfl_pkg::SEL_W,
  parameter int unsigned BASE_LOG2 = cfl_pkg::BASE_LOG2,
  parameter int unsigned TMR_W     = cfl_pkg::TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] period_sel,
  output logic             tick
);
  function automatic logic [TMR_W-1:0] period_last(input logic [SEL_W-1:0] sel);
    logic [TMR_W:0] span;
    span = (TMR_W+1)'(1) << (BASE_LOG2 + int'(sel));
    return span[TMR_W-1:0] - TMR_W'(1);
  endfunction

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] last_val;

  assign last_val = period_last(period_sel);
  assign tick     = (cnt >= last_val);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + TMR_W'(1);
  end

  // R6: a sample event never lasts more than one cycle
  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cfl_rx_shift.sv
module cfl_rx_shift #(
  parameter int unsigned WORD_W = cfl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              sdifs,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned BC_W = $clog2(WORD_W);

  logic [WORD_W-2:0] sh;
  logic [BC_W-1:0]   bcnt;
  logic              busy;
  logic              last_bit;

  assign last_bit  = (bcnt == BC_W'(WORD_W - 1));
  assign word_done = busy && !sdifs && last_bit;
  assign word      = {sh, sdi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      bcnt <= '0;
      busy <= 1'b0;
    end else if (sdifs) begin
      sh   <= (WORD_W-1)'(sdi);
      bcnt <= BC_W'(1);
      busy <= 1'b1;
    end else if (busy) begin
      sh <= {sh[WORD_W-3:0], sdi};
      if (last_bit) begin
        bcnt <= '0;
        busy <= 1'b0;
      end else begin
        bcnt <= bcnt + BC_W'(1);
      end
    end
  end

  // R1: two completed words are at least a word time apart
  assert_word_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);
  // R1: after a completed word the receiver waits for a new frame sync
  assert_idle_after_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !busy || $past(sdifs));
endmodule

// File: rtl/cfl_frame_ctrl.sv
module cfl_frame_ctrl #(
  parameter int unsigned DC_W  = cfl_pkg::DC_W,
  parameter int unsigned CNT_W = cfl_pkg::CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            word_done,
  input  logic [DC_W-1:0] dev_count,
  output logic            fwd,
  output logic            load_now,
  output logic            overrun
);
  function automatic logic [CNT_W-1:0] cascade_len(input logic [DC_W-1:0] dc);
    return CNT_W'(dc) + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             full;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] base_cnt;
  logic             base_full;
  logic [CNT_W-1:0] next_cnt;
  logic             accept;
  logic             period_short;

  assign len          = cascade_len(dev_count);
  assign base_cnt     = tick ? '0 : cnt;
  assign base_full    = tick ? 1'b0 : full;
  assign accept       = word_done && !base_full;
  assign next_cnt     = base_cnt + CNT_W'(1);
  assign load_now     = accept && (next_cnt >= len);
  assign fwd          = accept && !load_now;
  assign period_short = tick && !full && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      cnt     <= accept ? next_cnt : base_cnt;
      full    <= load_now | base_full;
      overrun <= overrun | period_short;
    end
  end

  // R2: the count never passes the longest possible cascade
  assert_cnt_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(1 << DC_W));
  // R5: a filled period neither forwards nor loads
  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !tick) |-> !fwd && !load_now);
  // R7: a sample event with no completing word leaves a cleared count
  assert_tick_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !word_done) |=> (cnt == '0) && !full);
  // R8: overrun is sticky
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: rtl/cfl_tx_shift.sv
module cfl_tx_shift #(
  parameter int unsigned WORD_W = cfl_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic [WORD_W-1:0] word,
  output logic              sdo,
  output logic              sdofs
);
  localparam int unsigned LEFT_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] sh;
  logic [LEFT_W-1:0] left;
  logic              fs;

  assign sdo   = (left != '0) && sh[WORD_W-1];
  assign sdofs = fs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      fs   <= 1'b0;
    end else if (fwd) begin
      sh   <= word;
      left <= LEFT_W'(WORD_W);
      fs   <= 1'b1;
    end else begin
      fs <= 1'b0;
      if (left != '0) begin
        sh   <= {sh[WORD_W-2:0], 1'b0};
        left <= left - LEFT_W'(1);
      end
    end
  end

  // R4: a forward request never cuts off a word still being sent
  assert_no_clobber_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> left <= LEFT_W'(1));
  // R4: the output frame sync lasts one cycle
  assert_fs_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdofs |=> !sdofs);
endmodule

// File: rtl/cfl_cascade_loader.sv
module cfl_cascade_loader #(
  parameter int unsigned WORD_W    = cfl_pkg::WORD_W,
  parameter int unsigned DC_W      = cfl_pkg::DC_W,
  parameter int unsigned SEL_W     = cfl_pkg::SEL_W,
  parameter int unsigned BASE_LOG2 = cfl_pkg::BASE_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  period_sel,
  input  logic [DC_W-1:0]   dev_count,
  input  logic              sdi,
  input  logic              sdifs,
  output logic              sdo,
  output logic              sdofs,
  output logic              smp_tick,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_load,
  output logic              overrun
);
  localparam int unsigned CNT_W = DC_W + 1;
  localparam int unsigned TMR_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic              word_done;
  logic [WORD_W-1:0] rx_word;
  logic              fwd;
  logic              load_now;
  logic [WORD_W-1:0] dac_q;
  logic              load_q;

  cfl_sample_timer #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .tick(smp_tick));

  cfl_rx_shift #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdifs(sdifs),
    .word_done(word_done), .word(rx_word));

  cfl_frame_ctrl #(.DC_W(DC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(smp_tick), .word_done(word_done),
    .dev_count(dev_count), .fwd(fwd), .load_now(load_now), .overrun(overrun));

  cfl_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fwd(fwd), .word(rx_word), .sdo(sdo), .sdofs(sdofs));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_q  <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load_now;
      if (load_now) dac_q <= rx_word;
    end
  end

  assign dac_word = dac_q;
  assign dac_load = load_q;

  // R3: the DAC register moves only together with the load strobe
  assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_word) |-> dac_load);
  // R3: the load strobe is one cycle wide
  assert_load_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |=> !dac_load);
  // R4/R3: a word is either forwarded or loaded, never both
  assert_fwd_xor_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd && load_now));
endmodule

// File: tb/test_cfl_cascade_loader.sv
module test_cfl_cascade_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  period_sel = '0;
  logic [2:0]  dev_count = '0;
  logic        sdi = 1'b0, sdifs = 1'b0;
  logic        sdo, sdofs, smp_tick, dac_load, overrun;
  logic [15:0] dac_word;

  cfl_cascade_loader i_cfl_cascade_loader (
    .clk(clk), .rst_n(rst_n), .period_sel(period_sel), .dev_count(dev_count),
    .sdi(sdi), .sdifs(sdifs), .sdo(sdo), .sdofs(sdofs), .smp_tick(smp_tick),
    .dac_word(dac_word), .dac_load(dac_load), .overrun(overrun));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // monitor of forwarded words and loads
  logic [15:0] fwd_w [0:31];
  logic [15:0] load_w [0:31];
  int load_c [0:31];
  int fwd_n = 0, load_n = 0, tn = 0;
  logic [15:0] tcap = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sdofs) begin
        tcap = {15'b0, sdo};
        tn = 1;
      end else if (tn > 0) begin
        tcap = {tcap[14:0], sdo};
        tn = tn + 1;
        if (tn == 16) begin
          if (fwd_n < 32) fwd_w[fwd_n] = tcap;
          fwd_n = fwd_n + 1;
          tn = 0;
        end
      end
      if (dac_load) begin
        if (load_n < 32) begin
          load_w[load_n] = dac_word;
          load_c[load_n] = cyc;
        end
        load_n = load_n + 1;
      end
    end
  end

  function automatic int exp_len(input int dc);
    return dc + 1;
  endfunction

  function automatic int exp_period(input int sel);
    int p = 256;
    for (int k = 0; k < sel; k++) p = p * 2;
    return p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    fwd_n = 0; load_n = 0; tn = 0;
  endtask

  task automatic do_reset(input int sel, input int dc);
    rst_n = 1'b0; sdi = 1'b0; sdifs = 1'b0;
    period_sel = 2'(sel); dev_count = 3'(dc);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_mon();
  endtask

  task automatic wait_tick(output int c);
    do @(negedge clk); while (!smp_tick);
    c = cyc;
  endtask

  task automatic idle(input int n);
    sdifs = 1'b0; sdi = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w, output int last_c);
    for (int i = 0; i < 16; i++) begin
      sdi = w[15 - i];
      sdifs = (i == 0);
      if (i == 15) last_c = cyc;
      @(negedge clk);
    end
    sdifs = 1'b0; sdi = 1'b0;
  endtask

  initial begin
    int c0, c1, lc, len, extra, gap;
    logic [15:0] words [0:15];
    int lastc [0:15];
    void'($urandom(32'd1234));

    // R9: reset state while held and after release
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 sdo", int'(sdo), 0);
    chk("R9 sdofs", int'(sdofs), 0);
    chk("R9 dac_word", int'(dac_word), 0);
    chk("R9 dac_load", int'(dac_load), 0);
    chk("R9 overrun", int'(overrun), 0);
    do_reset(0, 0);
    @(negedge clk);
    chk("R9 dac_word after release", int'(dac_word), 0);
    chk("R9 overrun after release", int'(overrun), 0);

    // R6: sample period for every select value
    for (int s = 0; s < 4; s++) begin
      do_reset(s, 0);
      wait_tick(c0);
      wait_tick(c1);
      chk($sformatf("R6 period sel=%0d", s), c1 - c0, exp_period(s));
    end

    // R2 R3 R4 R5: directed 000b and 111b, then random device counts
    for (int t = 0; t < 8; t++) begin
      int dc;
      dc = (t == 0) ? 0 : (t == 1) ? 7 : int'($urandom_range(0, 7));
      len = exp_len(dc);
      extra = int'($urandom_range(1, 2));
      do_reset(3, dc);
      wait_tick(c0);
      clear_mon();
      for (int k = 0; k < len + extra; k++) begin
        words[k] = 16'($urandom);
        gap = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, 9));
        idle(gap);
        send_word(words[k], lastc[k]);
      end
      idle(40);
      chk($sformatf("R2 R4 forwarded count dc=%0d", dc), fwd_n, len - 1);
      for (int k = 0; k < len - 1 && k < fwd_n; k++)
        chk($sformatf("R4 forwarded word %0d dc=%0d", k, dc), int'(fwd_w[k]), int'(words[k]));
      chk($sformatf("R3 R5 load count dc=%0d", dc), load_n, 1);
      if (load_n >= 1) begin
        chk($sformatf("R3 loaded word dc=%0d", dc), int'(load_w[0]), int'(words[len - 1]));
        chk($sformatf("R3 load cycle dc=%0d", dc), load_c[0], lastc[len - 1] + 1);
      end
      chk($sformatf("R5 dac holds dc=%0d", dc), int'(dac_word), int'(words[len - 1]));
      chk("R4 sdo idle low", int'(sdo), 0);
      wait_tick(c1);
      idle(1);
      chk($sformatf("R8 no overrun on full period dc=%0d", dc), int'(overrun), 0);
    end

    // R8 R7: short period sets overrun; count restarts in the next period
    do_reset(0, 3);
    wait_tick(c0);
    send_word(16'h1111, lc);
    send_word(16'h2222, lc);
    wait_tick(c1);
    idle(1);
    chk("R8 overrun after short period", int'(overrun), 1);
    clear_mon();
    for (int k = 0; k < 4; k++) begin
      words[k] = 16'hA000 + 16'(k);
      send_word(words[k], lastc[k]);
    end
    idle(40);
    chk("R7 count restarted: forwarded", fwd_n, 3);
    chk("R7 count restarted: loads", load_n, 1);
    chk("R7 loaded fourth word", int'(dac_word), int'(words[3]));
    chk("R8 overrun sticky", int'(overrun), 1);
    do_reset(0, 3);
    @(negedge clk);
    chk("R8 R9 overrun cleared by reset", int'(overrun), 0);

    // R8: a period with no words does not set overrun
    do_reset(0, 2);
    wait_tick(c0);
    wait_tick(c1);
    idle(1);
    chk("R8 empty period", int'(overrun), 0);

    // R1: frame sync mid-word restarts the word
    do_reset(0, 0);
    wait_tick(c0);
    clear_mon();
    for (int i = 0; i < 7; i++) begin
      sdi = 1'b1; sdifs = (i == 0);
      @(negedge clk);
    end
    send_word(16'h5A3C, lc);
    idle(20);
    chk("R1 resync loads", load_n, 1);
    chk("R1 resync word", int'(dac_word), 16'h5A3C);
    chk("R1 nothing forwarded", fwd_n, 0);

    // R7: word ending on the sample event counts in the new period
    do_reset(0, 1);
    wait_tick(c0);
    clear_mon();
    idle(exp_period(0) - 15);
    send_word(16'hC3A5, lc);
    chk("R7 last bit on tick cycle", lc, c0 + exp_period(0));
    idle(20);
    chk("R7 coincident word forwarded", fwd_n, 1);
    if (fwd_n >= 1) chk("R7 coincident word value", int'(fwd_w[0]), 16'hC3A5);
    chk("R7 coincident word not loaded", load_n, 0);
    send_word(16'h0F0F, lc);
    idle(4);
    chk("R7 second word loads", load_n, 1);
    chk("R7 second word value", int'(dac_word), 16'h0F0F);
    chk("R8 no overrun after empty old period", int'(overrun), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule